// File: doc/BRIEF.md
# Bit-7 Status Polling Completion Checker

This block runs on the host side of a parallel flash interface. It decides when a program or an erase operation has finished inside the memory. After the command sequence has been written, the host pulses `start_i` together with the operation kind, the target word address and the byte that should end up in the array. The block waits a short guard interval and then issues fixed-shape read cycles. Each read cycle places an address on the bus, holds the output-enable strobe low for a set number of clocks and samples the byte. The block looks only at bit 7 of each sampled byte until that bit shows completion.

The other seven bits can still lag when bit 7 first flips, so a completed poll is always followed by one confirm read. The byte from that confirm read is compared in full against the expected value: the programmed byte, or all ones after an erase. The block then pulses `done_o`, and it pulses `verify_fail_o` in the same cycle if the comparison fails. If completion never appears within a parameterised number of polls, the block pulses `timeout_o` instead.

Top module: `dpoll_ctrl`

## Requirements
- R1: After reset, `busy_o` is 0, `bus_oe_n_o` is 1 (strobe inactive), and `done_o`, `verify_fail_o` and `timeout_o` are 0.
- R2: Counting the cycle that follows the clock edge which samples `start_i` as cycle 1, the strobe first goes low in cycle GAP_CLKS+3, so no read overlaps the end of the last command write.
- R3: Every read holds `bus_oe_n_o` low for exactly OE_CLKS consecutive cycles with a stable address, and successive reads are separated by at least two cycles with the strobe high.
- R4: For a program operation (`op_erase_i`=0), every read uses `addr_i` unchanged.
- R5: For an erase operation (`op_erase_i`=1), every read uses `addr_i` with its low SECT_AW bits forced to 0, which is the first word of the sector being erased.
- R6: For a program operation, a poll counts as complete when bit 7 of the read byte equals bit 7 of `exp_data_i`. The inverse value means busy.
- R7: For an erase operation, a poll counts as complete when bit 7 reads 1. A 0 means busy.
- R8: After a completing poll, exactly one further read is made. If the operation completes on poll k, `done_o` pulses in cycle GAP_CLKS+2+(k+1)*(OE_CLKS+2).
- R9: `verify_fail_o` pulses together with `done_o` exactly when the confirm byte differs from `exp_data_i` (program) or from 8'hFF (erase).
- R10: If none of MAX_POLLS polls completes, no further read is made and `timeout_o` pulses in cycle GAP_CLKS+2+MAX_POLLS*(OE_CLKS+2), with no `done_o`.
- R11: A `start_i` pulse while `busy_o` is 1 has no effect on addresses, read count or result timing.
- R12: `done_o`, `verify_fail_o` and `timeout_o` are single-cycle pulses. `busy_o` is 1 from cycle 1 until the result pulse, and it is 0 in the cycle of the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin waiting for an operation (one-cycle pulse) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| addr_i | input | AW | Programmed word address, or any address in the erased sector |
| exp_data_i | input | 8 | Byte that was programmed |
| bus_addr_o | output | AW | Memory bus address |
| bus_oe_n_o | output | 1 | Memory output-enable strobe, active low |
| bus_data_i | input | 8 | Memory read data |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | Operation finished (pulse) |
| verify_fail_o | output | 1 | Confirm byte mismatched (pulse with done_o) |
| timeout_o | output | 1 | Poll limit reached without completion (pulse) |

## Verification
All timing is counted from the edge that samples `start_i`. The first strobe falls in cycle GAP_CLKS+3. Each read then takes OE_CLKS+2 cycles, and a result pulse lands one cycle after the release phase of the last read, so with k completing polls `done_o` is due in cycle GAP_CLKS+2+(k+1)*(OE_CLKS+2) and a timeout in GAP_CLKS+2+MAX_POLLS*(OE_CLKS+2). The bench counts posedges from the start edge and samples on the falling edge. It compares the cycle in which a pulse is first seen against these formulas, checks that the next cycle is low, and measures every strobe-low run and every read address as it happens. A bus model returns busy bytes for a chosen number of reads, then one byte in which only bit 7 has settled, then the final byte, so the read count, the confirm read and the verify comparison can all be predicted.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    RC_IDLE,
    RC_SETUP,
    RC_STROBE,
    RC_REL
  } rc_state_t;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_GAP,
    CT_POLL,
    CT_CONF
  } ct_state_t;

  // Bit-7 rule: program finishes when bit 7 matches the target's bit 7,
  // erase finishes when bit 7 reads 1.
  function automatic logic poll_finished(input logic [7:0] rd,
                                         input logic [7:0] target,
                                         input logic       erase);
    if (erase) return rd[7];
    return rd[7] == target[7];
  endfunction

  // Byte the confirm read must return in full.
  function automatic logic [7:0] final_ref(input logic [7:0] target,
                                           input logic       erase);
    return erase ? ERASED_BYTE : target;
  endfunction

endpackage

// File: rtl/dpoll_rdcyc.sv
module dpoll_rdcyc
  import dpoll_pkg::*;
#(
  parameter int AW      = 16,
  parameter int OE_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_oe_n_o,
  input  logic [7:0]    bus_data_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [7:0]    data_o
);

  localparam int CW = $clog2(OE_CLKS + 1);

  rc_state_t      st;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RC_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st)
        RC_IDLE, RC_REL: begin
          if (go_i) begin
            addr_q <= addr_i;
            st     <= RC_SETUP;
          end else begin
            st     <= RC_IDLE;
          end
        end
        RC_SETUP: begin
          cnt <= '0;
          st  <= RC_STROBE;
        end
        RC_STROBE: begin
          if (cnt == CW'(OE_CLKS - 1)) begin
            data_q <= bus_data_i;
            st     <= RC_REL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RC_IDLE;
      endcase
    end
  end

  assign bus_addr_o = addr_q;
  assign bus_oe_n_o = (st != RC_STROBE);
  assign ready_o    = (st == RC_IDLE) || (st == RC_REL);
  assign done_o     = (st == RC_REL);
  assign data_o     = data_q;

  // R3: address does not move while the strobe is held low
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n_o && $past(!bus_oe_n_o)) |-> $stable(bus_addr_o));

  // R3: a request only arrives when the sequencer can accept it
  p_go_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> ready_o);

  // R3: strobe is released for the cycle after sampling
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_n_o) |-> done_o);

endmodule

// File: rtl/dpoll_judge.sv
module dpoll_judge
  import dpoll_pkg::*;
(
  input  logic [7:0] rd_data_i,
  input  logic [7:0] target_i,
  input  logic       erase_i,
  output logic       finished_o,
  output logic       match_o
);

  assign finished_o = poll_finished(rd_data_i, target_i, erase_i);
  assign match_o    = (rd_data_i == final_ref(target_i, erase_i));

endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
  import dpoll_pkg::*;
#(
  parameter int AW        = 16,
  parameter int SECT_AW   = 12,
  parameter int OE_CLKS   = 3,
  parameter int GAP_CLKS  = 2,
  parameter int MAX_POLLS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    exp_data_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_oe_n_o,
  input  logic [7:0]    bus_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          verify_fail_o,
  output logic          timeout_o
);

  localparam int GW = $clog2(GAP_CLKS + 2);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [AW-1:0] SECT_MASK = ~((AW'(1) << SECT_AW) - AW'(1));

  // Erase polls at the first word of the sector, program at the word itself.
  function automatic logic [AW-1:0] poll_addr(input logic [AW-1:0] a,
                                              input logic          erase);
    return erase ? (a & SECT_MASK) : a;
  endfunction

  ct_state_t      st;
  logic [GW-1:0]  gcnt;
  logic [PW-1:0]  pcnt;
  logic           op_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     exp_q;
  logic           done_q, vf_q, to_q;

  // Named internal events
  logic           rd_go;
  logic           rd_done;
  logic           rd_ready;
  logic [7:0]     rd_data;
  logic           poll_fin;
  logic           conf_match;
  logic           gap_over;
  logic           last_poll;

  assign gap_over  = (st == CT_GAP) && (gcnt == '0);
  assign last_poll = (pcnt == PW'(MAX_POLLS));

  always_comb begin
    rd_go = 1'b0;
    case (st)
      CT_GAP:  rd_go = gap_over;
      CT_POLL: rd_go = rd_done && (poll_fin || !last_poll);
      default: rd_go = 1'b0;
    endcase
  end

  dpoll_rdcyc #(
    .AW      (AW),
    .OE_CLKS (OE_CLKS)
  ) u_rdcyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (rd_go),
    .addr_i     (addr_q),
    .bus_addr_o (bus_addr_o),
    .bus_oe_n_o (bus_oe_n_o),
    .bus_data_i (bus_data_i),
    .ready_o    (rd_ready),
    .done_o     (rd_done),
    .data_o     (rd_data)
  );

  dpoll_judge u_judge (
    .rd_data_i  (rd_data),
    .target_i   (exp_q),
    .erase_i    (op_q),
    .finished_o (poll_fin),
    .match_o    (conf_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CT_IDLE;
      gcnt   <= '0;
      pcnt   <= '0;
      op_q   <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
      done_q <= 1'b0;
      vf_q   <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      vf_q   <= 1'b0;
      to_q   <= 1'b0;
      case (st)
        CT_IDLE: begin
          if (start_i) begin
            op_q   <= op_erase_i;
            addr_q <= poll_addr(addr_i, op_erase_i);
            exp_q  <= exp_data_i;
            gcnt   <= GW'(GAP_CLKS);
            pcnt   <= '0;
            st     <= CT_GAP;
          end
        end
        CT_GAP: begin
          if (gap_over) begin
            pcnt <= PW'(1);
            st   <= CT_POLL;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        CT_POLL: begin
          if (rd_done) begin
            if (poll_fin) begin
              st <= CT_CONF;
            end else if (last_poll) begin
              to_q <= 1'b1;
              st   <= CT_IDLE;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        CT_CONF: begin
          if (rd_done) begin
            done_q <= 1'b1;
            vf_q   <= !conf_match;
            st     <= CT_IDLE;
          end
        end
        default: st <= CT_IDLE;
      endcase
    end
  end

  assign busy_o        = (st != CT_IDLE);
  assign done_o        = done_q;
  assign verify_fail_o = vf_q;
  assign timeout_o     = to_q;

  // R10: a wait ends in exactly one kind of result
  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  // R9: verify failure is only reported alongside done
  p_vf_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    verify_fail_o |-> done_o);

  // R12: result flags are single-cycle pulses
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_to_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R8: every result follows the end of a read cycle
  p_result_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> $past(rd_done));

  // R11: a start while busy leaves the captured request untouched
  p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(addr_q) && $stable(exp_q) && $stable(op_q)));

  // R5: erase reads land on a sector boundary
  p_sector_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n_o && op_q) |-> ((bus_addr_o & ~SECT_MASK) == '0));

  // R3: the strobe is only driven during a wait
  p_oe_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n_o |-> busy_o);

  // R2: the first read request waits for the guard interval
  p_first_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && st == CT_GAP) |-> (rd_ready && pcnt == '0));

endmodule

// File: tb/tb_dpoll_ctrl.sv
module tb_dpoll_ctrl;

  localparam int AW = 8, SAW = 4, K = 2, G = 2, MAXP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    exp_d = '0;
  logic [AW-1:0] bus_addr;
  logic          oe_n;
  logic [7:0]    bus_data;
  logic          busy, done, vfail, tmo;

  dpoll_ctrl #(.AW(AW), .SECT_AW(SAW), .OE_CLKS(K), .GAP_CLKS(G), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_erase_i(op_erase),
    .addr_i(addr), .exp_data_i(exp_d), .bus_addr_o(bus_addr), .bus_oe_n_o(oe_n),
    .bus_data_i(bus_data), .busy_o(busy), .done_o(done),
    .verify_fail_o(vfail), .timeout_o(tmo)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int ncyc = 0;
  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  // Bus model
  int         rdidx = 0, busy_reads = 0, s0 = 0, first_fall = 0, lowrun = 0;
  bit         m_erase = 0;
  logic [7:0] m_exp = '0, m_fin = '0;
  logic [AW-1:0] want_addr = '0;
  logic       prev_oe = 1'b1;

  always_comb begin
    if (rdidx <= busy_reads)
      bus_data = m_erase ? {1'b0, 7'(rdidx * 5)} : {~m_exp[7], 7'(rdidx * 3)};
    else if (rdidx == busy_reads + 1)
      bus_data = m_erase ? 8'hAA : {m_exp[7], ~m_exp[6:0]};
    else
      bus_data = m_fin;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!oe_n && prev_oe) begin
        rdidx++;
        if (rdidx == 1) first_fall = ncyc - s0;
        chk(bus_addr == want_addr, m_erase ? "R5 erase poll address" : "R4 program poll address",
            int'(bus_addr), int'(want_addr));
      end
      if (!oe_n) lowrun++;
      else if (lowrun != 0) begin
        chk(lowrun == K, "R3 strobe width", lowrun, K);
        lowrun = 0;
      end
    end
    prev_oe = oe_n;
  end

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [7:0] e,
                        input int breads, input bit bad_fin, input bit mid_start);
    int c;
    int n;
    int exp_cyc;
    bit exp_to;
    logic [7:0] fin;
    fin = er ? 8'hFF : e;
    if (bad_fin) fin = fin ^ 8'h04;
    m_erase = er; m_exp = e; m_fin = fin; busy_reads = breads;
    want_addr = er ? (a & ~AW'((1 << SAW) - 1)) : a;
    rdidx = 0; first_fall = 0;
    exp_to = (breads + 1 > MAXP);
    n = exp_to ? MAXP : breads + 2;
    exp_cyc = G + 2 + n * (K + 2);
    @(negedge clk);
    start = 1'b1; op_erase = er; addr = a; exp_d = e; s0 = ncyc;
    c = 0;
    while (1) begin
      @(negedge clk);
      c = ncyc - s0;
      if (mid_start && c == 6) begin
        start = 1'b1; addr = ~a; exp_d = ~e; op_erase = ~er;
      end else start = 1'b0;
      if (c == 1) chk(busy == 1'b1, "R12 busy after start", busy, 1);
      if (done || tmo || c > 400) break;
    end
    start = 1'b0;
    chk(c == exp_cyc, exp_to ? "R10 timeout cycle" : (er ? "R7 R8 erase done cycle" : "R6 R8 program done cycle"),
        c, exp_cyc);
    chk(tmo == exp_to && done == !exp_to, "R10 result kind", int'({done, tmo}), int'({!exp_to, exp_to}));
    if (!exp_to) chk(vfail == bad_fin, "R9 verify flag", vfail, bad_fin);
    chk(rdidx == n, "R8 read count", rdidx, n);
    chk(first_fall == G + 3, "R2 first strobe cycle", first_fall, G + 3);
    chk(busy == 1'b0, "R12 busy low with result", busy, 0);
    @(negedge clk);
    chk(!done && !tmo && !vfail, "R12 single-cycle pulse", int'({done, tmo, vfail}), 0);
    chk(oe_n == 1'b1, "R10 no read after result", oe_n, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && oe_n == 1 && done == 0 && vfail == 0 && tmo == 0, "R1 reset state",
        int'({busy, oe_n, done, vfail, tmo}), int'(5'b01000));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && oe_n == 1, "R1 idle after reset", int'({busy, oe_n}), 1);
    // Sweep: both operations, 16 target bytes, 0..3 busy reads
    for (int op = 0; op < 2; op++)
      for (int e = 0; e < 16; e++)
        for (int b = 0; b < 4; b++)
          run_op(op[0], AW'(e * 13 + b * 7 + 5), 8'(e * 17), b, 1'b0, 1'b0);
    // Boundaries of the poll limit
    run_op(1'b0, 8'h3C, 8'h80, MAXP - 1, 1'b0, 1'b0);
    run_op(1'b1, 8'hC7, 8'h00, MAXP - 1, 1'b0, 1'b0);
    run_op(1'b0, 8'h11, 8'h7F, MAXP, 1'b0, 1'b0);
    run_op(1'b1, 8'h5A, 8'h00, MAXP + 3, 1'b0, 1'b0);
    // Confirm byte mismatch (R9)
    run_op(1'b0, 8'h42, 8'hC3, 2, 1'b1, 1'b0);
    run_op(1'b1, 8'h9E, 8'h00, 1, 1'b1, 1'b0);
    // Start while busy ignored (R11)
    run_op(1'b0, 8'h27, 8'h95, 3, 1'b0, 1'b1);
    run_op(1'b1, 8'hB3, 8'h00, 2, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule